// File: doc/BRIEF.md
# Microcontroller Interrupt Controller

This block gathers the interrupt requests of a small 8-bit processor core and decides when the core should branch to its interrupt handler. Eleven sources feed it. One is an external pin whose active edge software selects. The others are a pin-change strobe, a timer-0 overflow strobe and eight peripheral event strobes. Every source owns a sticky flag and an individual enable. A single global enable gates the whole set.

Software reaches four byte-wide registers through a simple register port. These are the core control register, an option register that holds the edge select, the peripheral flag register and the peripheral enable register. The core sees a take-interrupt request and a fixed vector address. On entry it receives a one-cycle pulse telling it to push the return address. It also gets a wake signal that it uses while sleeping. The core returns an entry acknowledge strobe and a return strobe.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00, `irq_take`, `push_ret` and `wake` are 0, and `irq_vector` is 0x0004.
- R2: An event strobe sets its flag at the next clock edge, whatever the state of the individual enable and the global enable.
- R3: `irq_take` is 1 exactly when the global enable (control bit 7) is 1 and at least one flag has its enable set.
- R4: An `irq_ack` strobe clears the global enable at the next edge and raises `push_ret` for that one following cycle. `irq_vector` always reads 0x0004.
- R5: An `irq_ret` strobe sets the global enable at the next edge. A flag that is still set and enabled then raises `irq_take` again.
- R6: The external pin is synchronized by two flops. A rising edge sets control bit 1 when option bit 6 is 1, and a falling edge sets it when option bit 6 is 0. The flag becomes visible on the third clock edge after the pin changes. The opposite edge leaves the flag at 0.
- R7: Flags change only through software writes or their own events. A flag that is set stays set until software writes it to 0.
- R8: When a software write and a hardware event hit the same flag in the same cycle, the flag ends up set.
- R9: While a write to the control register clears bit 7, `irq_take` is 0 in that same cycle. The pending flag stays set and is taken once bit 7 is written back to 1.
- R10: With `sleep_mode` at 1, `wake` is 1 when the external flag or the pin-change flag is set together with its enable, even with the global enable at 0. Peripheral flags never assert `wake`.
- R11: Register map: address 0 is control, with bit 7 global enable, bit 5/4/3 timer-0/external/pin-change enable, bit 2/1/0 timer-0/external/pin-change flag, and bit 6 reading 0. Address 1 is option, with only bit 6 stored. Address 2 is peripheral flags, where bit i follows `periph_evt[i]`. Address 3 is peripheral enables.
- R12: The global enable is updated with this priority: `irq_ack` (clear) over `irq_ret` (set) over a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| pinchg_evt | input | 1 | Pin-change event strobe |
| tmr0_evt | input | 1 | Timer-0 overflow strobe |
| periph_evt | input | 8 | Peripheral event strobes |
| sleep_mode | input | 1 | Core is sleeping |
| irq_ack | input | 1 | Core is entering the handler |
| irq_ret | input | 1 | Core executed return-from-interrupt |
| irq_take | output | 1 | Request to branch to the vector |
| irq_vector | output | 13 | Handler address, constant 0x0004 |
| push_ret | output | 1 | One-cycle pulse: push return address |
| wake | output | 1 | Wake request for sleep mode |

## Verification
The bench first targets the cycle in which software clears the global enable. A design that registers the gate would let a request slip through in that cycle, and one that drops the flag would never service it. A collision of a software flag clear with an event in the same cycle catches a design that lets the write win and loses the event. Edge tests count the exact clock edges from pin change to flag and drive the unselected edge, so a missing synchronizer stage or an inverted select shows up. Wake is checked with the global enable off and with only a peripheral pending, which exposes a wake gated by the global enable or fed by the wrong sources.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_OPT   = 2'd1;
  localparam logic [ADDR_W-1:0] A_PFLAG = 2'd2;
  localparam logic [ADDR_W-1:0] A_PEN   = 2'd3;

  // core sources: index 0 pin-change, 1 external, 2 timer-0
  localparam int CORE_N     = 3;
  localparam int CORE_EN_LO = 3;  // enable of core source i sits at bit i+3
  localparam int GIE_BIT    = 7;
  localparam int EDGE_BIT   = 6;

  function automatic logic any_pending(input logic [CORE_N-1:0] cf,
                                       input logic [CORE_N-1:0] ce,
                                       input logic [DATA_W-1:0] pf,
                                       input logic [DATA_W-1:0] pe);
    return (|(cf & ce)) | (|(pf & pe));
  endfunction

  function automatic logic wake_pending(input logic [CORE_N-1:0] cf,
                                        input logic [CORE_N-1:0] ce);
    return |(cf[1:0] & ce[1:0]);
  endfunction
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              level;
  logic              rise_w;
  logic              fall_w;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  assign level = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise_w   = level & ~prev_q;
  assign fall_w   = ~level & prev_q;
  assign edge_hit = rise_sel ? rise_w : fall_w;

  a_r6_single_edge_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_w, fall_w}));
  a_r6_hit_matches_select: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |-> (level == rise_sel));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_we,
  input  logic [N-1:0] sw_data,
  input  logic [N-1:0] hw_set,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (sw_we ? sw_data : flags) | hw_set;
  end

  a_r8_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((flags & $past(hw_set)) == $past(hw_set)));
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && hw_set == '0) |=> (flags == $past(flags)));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int              PERIPH_N   = 8,
  parameter int              PC_W       = 13,
  parameter logic [PC_W-1:0] VECTOR     = 13'h0004,
  parameter int              SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                ext_pin,
  input  logic                pinchg_evt,
  input  logic                tmr0_evt,
  input  logic [PERIPH_N-1:0] periph_evt,
  input  logic                sleep_mode,
  input  logic                irq_ack,
  input  logic                irq_ret,
  output logic                irq_take,
  output logic [PC_W-1:0]     irq_vector,
  output logic                push_ret,
  output logic                wake
);
  logic                gie_q;
  logic [CORE_N-1:0]   core_en_q;
  logic                edge_sel_q;
  logic [PERIPH_N-1:0] per_en_q;
  logic [CORE_N-1:0]   core_flags;
  logic [PERIPH_N-1:0] per_flags;
  logic                push_q;

  // named internal events
  logic wr_ctrl, wr_opt, wr_pflag, wr_pen;
  logic gie_clear_wr;
  logic ext_hit;
  logic pend_any;
  logic [CORE_N-1:0] core_hw;

  assign wr_ctrl      = reg_we && (reg_addr == A_CTRL);
  assign wr_opt       = reg_we && (reg_addr == A_OPT);
  assign wr_pflag     = reg_we && (reg_addr == A_PFLAG);
  assign wr_pen       = reg_we && (reg_addr == A_PEN);
  assign gie_clear_wr = wr_ctrl && !reg_wdata[GIE_BIT];

  irq_pin_edge #(.STAGES(SYNC_DEPTH)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (ext_pin),
    .rise_sel (edge_sel_q),
    .edge_hit (ext_hit)
  );

  assign core_hw = {tmr0_evt, ext_hit, pinchg_evt};

  irq_flag_bank #(.N(CORE_N)) u_core_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_we   (wr_ctrl),
    .sw_data (reg_wdata[CORE_N-1:0]),
    .hw_set  (core_hw),
    .flags   (core_flags)
  );

  irq_flag_bank #(.N(PERIPH_N)) u_per_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_we   (wr_pflag),
    .sw_data (reg_wdata[PERIPH_N-1:0]),
    .hw_set  (periph_evt),
    .flags   (per_flags)
  );

  // enables and option
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_en_q  <= '0;
      edge_sel_q <= 1'b0;
      per_en_q   <= '0;
    end else begin
      if (wr_ctrl) core_en_q  <= reg_wdata[CORE_EN_LO +: CORE_N];
      if (wr_opt)  edge_sel_q <= reg_wdata[EDGE_BIT];
      if (wr_pen)  per_en_q   <= reg_wdata[PERIPH_N-1:0];
    end
  end

  // global enable: entry clears, return sets, then software
  always_ff @(posedge clk) begin
    if (!rst_n)       gie_q <= 1'b0;
    else if (irq_ack) gie_q <= 1'b0;
    else if (irq_ret) gie_q <= 1'b1;
    else if (wr_ctrl) gie_q <= reg_wdata[GIE_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) push_q <= 1'b0;
    else        push_q <= irq_ack;
  end

  assign pend_any   = any_pending(core_flags, core_en_q,
                                  DATA_W'(per_flags), DATA_W'(per_en_q));
  assign irq_take   = gie_q && pend_any && !gie_clear_wr;
  assign push_ret   = push_q;
  assign irq_vector = VECTOR;
  assign wake       = sleep_mode && wake_pending(core_flags, core_en_q);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: begin
        reg_rdata[GIE_BIT]                 = gie_q;
        reg_rdata[CORE_EN_LO +: CORE_N]    = core_en_q;
        reg_rdata[CORE_N-1:0]              = core_flags;
      end
      A_OPT:   reg_rdata[EDGE_BIT]         = edge_sel_q;
      A_PFLAG: reg_rdata[PERIPH_N-1:0]     = per_flags;
      A_PEN:   reg_rdata[PERIPH_N-1:0]     = per_en_q;
      default: reg_rdata = '0;
    endcase
  end

  a_r3_take_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> gie_q);
  a_r4_ack_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!gie_q && push_ret));
  a_r4_push_single: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ret && !$past(irq_ack, 2)) |=> !push_ret);
  a_r5_ret_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack) |=> gie_q);
  a_r10_wake_only_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> sleep_mode);
  a_r9_clear_blocks_take: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !reg_wdata[GIE_BIT] && !irq_ret && !irq_ack) |=> !gie_q);
endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext_pin = 1'b0;
  logic       pinchg_evt = 1'b0;
  logic       tmr0_evt = 1'b0;
  logic [7:0] periph_evt = '0;
  logic       sleep_mode = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq_ret = 1'b0;
  logic       irq_take;
  logic [12:0] irq_vector;
  logic       push_ret;
  logic       wake;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
    .pinchg_evt(pinchg_evt), .tmr0_evt(tmr0_evt), .periph_evt(periph_evt),
    .sleep_mode(sleep_mode), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_take(irq_take), .irq_vector(irq_vector), .push_ret(push_ret),
    .wake(wake)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reg reset", d, 8'h00);
    end
    check("R1 take", irq_take, 0);
    check("R1 push", push_ret, 0);
    check("R1 wake", wake, 0);
    check("R4 vector", irq_vector, 13'h0004);
  endtask

  task automatic t_latch_and_gate();
    logic [7:0] d;
    periph_evt = 8'h20; tick(); periph_evt = '0;
    rd(2'd2, d);
    check("R2 flag latch without enable", d, 8'h20);
    wr(2'd3, 8'h20);
    #0.5 check("R3 no take while global off", irq_take, 0);
    wr(2'd0, 8'h80);
    #0.5 check("R3 take with global on", irq_take, 1);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    check("R4 push pulse", push_ret, 1);
    check("R4 take dropped", irq_take, 0);
    rd(2'd0, d);
    check("R4 global cleared", d[7], 0);
    tick();
    check("R4 push one cycle", push_ret, 0);
    irq_ret = 1'b1; tick(); irq_ret = 1'b0;
    check("R5 retake after return", irq_take, 1);
    rd(2'd2, d);
    check("R7 flag still set", d, 8'h20);
    wr(2'd2, 8'h00);
    #0.5 check("R7 cleared by write", irq_take, 0);
  endtask

  task automatic t_clear_cycle();
    logic [7:0] d;
    periph_evt = 8'h20; tick(); periph_evt = '0;
    check("R9 pending before clear", irq_take, 1);
    reg_addr = 2'd0; reg_wdata = 8'h00; reg_we = 1'b1;
    #0.5 check("R9 no take in clearing cycle", irq_take, 0);
    tick(); reg_we = 1'b0;
    rd(2'd2, d);
    check("R9 flag stays pending", d, 8'h20);
    check("R9 no take after clear", irq_take, 0);
    wr(2'd0, 8'h80);
    #0.5 check("R9 taken when restored", irq_take, 1);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00); wr(2'd0, 8'h00);
  endtask

  task automatic t_hw_wins();
    logic [7:0] d;
    wr(2'd2, 8'h08);
    periph_evt = 8'h04;
    wr(2'd2, 8'h00);
    periph_evt = '0;
    rd(2'd2, d);
    check("R8 event beats write", d, 8'h04);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_ext_edge();
    logic [7:0] d;
    wr(2'd1, 8'h40);
    ext_pin = 1'b1; tick(2);
    rd(2'd0, d); check("R6 not yet after two edges", d[1], 0);
    tick();
    rd(2'd0, d); check("R6 rising flag on third edge", d[1], 1);
    wr(2'd0, 8'h00);
    ext_pin = 1'b0; tick(4);
    rd(2'd0, d); check("R6 falling ignored in rising mode", d, 8'h00);
    wr(2'd1, 8'h00);
    ext_pin = 1'b1; tick(4);
    rd(2'd0, d); check("R6 rising ignored in falling mode", d, 8'h00);
    ext_pin = 1'b0; tick(3);
    rd(2'd0, d); check("R6 falling flag", d, 8'h02);
  endtask

  task automatic t_wake();
    wr(2'd0, 8'h00);
    sleep_mode = 1'b1;
    periph_evt = 8'h01; tick(); periph_evt = '0;
    wr(2'd3, 8'h01);
    #0.5 check("R10 peripheral does not wake", wake, 0);
    wr(2'd0, 8'h08);
    pinchg_evt = 1'b1; tick(); pinchg_evt = 1'b0;
    check("R10 wake without global", wake, 1);
    check("R10 no take without global", irq_take, 0);
    sleep_mode = 1'b0;
    #0.5 check("R10 wake needs sleep", wake, 0);
    wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
  endtask

  task automatic t_map_priority();
    logic [7:0] d;
    tmr0_evt = 1'b1; tick(); tmr0_evt = 1'b0;
    rd(2'd0, d); check("R11 timer-0 flag bit 2", d, 8'h04);
    wr(2'd1, 8'hFF);
    rd(2'd1, d); check("R11 option only bit 6", d, 8'h40);
    wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R11 control bit 6 reads 0", d, 8'hBF);
    irq_ack = 1'b1; irq_ret = 1'b1; tick(); irq_ack = 1'b0; irq_ret = 1'b0;
    rd(2'd0, d); check("R12 entry beats return", d[7], 0);
    irq_ret = 1'b1; wr(2'd0, 8'h00); irq_ret = 1'b0;
    rd(2'd0, d); check("R12 return beats write", d[7], 1);
    wr(2'd0, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_latch_and_gate();
    t_clear_cycle();
    t_hw_wins();
    t_ext_edge();
    t_wake();
    t_map_priority();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule